// File: doc/BRIEF.md
# Configuration Capability Chain Engine

This block maintains the singly linked chain of capability structures that lives in the device-specific part of a 256-byte configuration space. It is a sequential engine. It reaches the configuration bytes through a byte-wide port that does one access per cycle. Read data is combinational and returns in the same cycle as the address. The engine keeps its own map of which bytes above the fixed header belong to a capability.

A requester issues one of three commands with a one-cycle request strobe:

- **Add** searches the byte map first-fit for a free run of the requested length. It writes the identifier byte and the link byte of the new entry. It splices the entry in front of the chain, sets the chain-present flag in the status byte, and locks the bytes of the entry.
- **Find** walks the chain and returns the offset of the first entry with a given identifier.
- **Remove** walks the chain, bypasses the matching entry by rewriting the link that pointed at it, and unlocks its bytes. It drops the chain-present flag once the chain is empty.

A walk gives up after a fixed number of hops, so a corrupted chain cannot hang it.

Top module: `cap_chain_engine`

## Requirements
- R1: A request is taken only in a cycle where `busy` is low. `done` is high for exactly one cycle at the end of every command, with `result` valid in that cycle. `busy` is low in the cycle after `done`.
- R2: Add considers start offsets from 64 up to 255 in ascending order. It restarts its candidate run after every locked byte and returns the lowest start of an unlocked run of `req_len` bytes. A run may end exactly at byte 255.
- R3: Add returns 0 and performs no write and no lock change when `req_len` is below 2 or when no run fits below offset 256.
- R4: A successful add at offset N writes the identifier to byte N. It writes the previous content of byte 0x34 to byte N+1, and then writes N to byte 0x34.
- R5: A successful add rewrites status byte 0x06 with bit 4 set and every other bit unchanged.
- R6: A successful add locks bytes N to N+len-1. Bit k of `lock_map` stands for byte 64+k. When no command is running, `lock_map` does not change.
- R7: Find returns 0 when bit 4 of byte 0x06 is clear. Otherwise it follows links starting at byte 0x34 and returns the first entry whose identifier byte matches. It returns 0 when it reads a zero link.
- R8: A walk that has visited 48 entries without a match ends with result 0. For a chain that loops on itself, find takes 98 cycles from the cycle after the request to `done`, both included.
- R9: Remove of a present entry at N writes byte N+1 into the link byte that pointed at N, unlocks its `req_len` bytes and returns N. Remove of an absent identifier returns 0 with no write.
- R10: When a remove leaves byte 0x34 at zero, status byte 0x06 is rewritten with bit 4 cleared and the other bits unchanged.
- R11: Writes go only to byte 0x06, byte 0x34 or bytes at 64 and above, and never while `busy` is low.
- R12: Command codes are 0 add, 1 find, 2 remove. Code 3 completes with result 0, no write and no lock change.
- R13: After reset `busy`, `done`, `mem_we` are low and `lock_map` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command strobe, taken when busy is low |
| req_cmd | input | 2 | 0 add, 1 find, 2 remove, 3 no operation |
| req_id | input | 8 | Capability identifier |
| req_len | input | 8 | Entry length in bytes (add, remove) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | Offset found or allocated, 0 on failure |
| mem_addr | output | 8 | Configuration byte address |
| mem_we | output | 1 | Byte write enable |
| mem_wdata | output | 8 | Byte write data |
| mem_rdata | input | 8 | Byte read data, same cycle as mem_addr |
| lock_map | output | 192 | Lock bit per byte from offset 64 upward |

## Verification
The assertions rely on some conditions of use:

- `mem_rdata` reflects the byte addressed in the same cycle.
- Nothing but the engine writes the configuration bytes while a command runs.
- On remove, `req_len` equals the length used when the entry was added.

The stimulus meets these conditions. It drives requests only at falling edges while `busy` is low. It pairs every remove with the length of its add. It corrupts the chain through the bench memory model only between commands, when the engine is idle.

// File: rtl/cap_chain_pkg.sv
package cap_chain_pkg;

   typedef enum logic [1:0] {
      CMD_ADD  = 2'd0,
      CMD_FIND = 2'd1,
      CMD_DEL  = 2'd2,
      CMD_NOP  = 2'd3
   } cap_cmd_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_SCAN,
      S_W_ID,
      S_RD_HEAD,
      S_W_LINK,
      S_W_HEAD,
      S_RD_ST,
      S_W_ST,
      S_CHK_ST,
      S_WALK_PTR,
      S_WALK_ID,
      S_RD_NEXT,
      S_W_PREV,
      S_FIN
   } cap_state_e;

endpackage

// File: rtl/cap_lock_map.sv
module cap_lock_map #(
   parameter int AW      = 8,
   parameter int HDR_END = 64,
   localparam int SPACE  = 1 << AW,
   localparam int LOCK_W = SPACE - HDR_END
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic              clr_en,
   input  logic [AW-1:0]     base,
   input  logic [AW-1:0]     len,
   output logic [LOCK_W-1:0] map_o
);

   logic [AW:0] upper;
   assign upper = {1'b0, base} + {1'b0, len};

   for (genvar i = 0; i < LOCK_W; i++) begin : g_byte
      localparam logic [AW:0] OFF = (AW+1)'(HDR_END + i);
      logic in_rng;
      assign in_rng = (OFF >= {1'b0, base}) && (OFF < upper);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 map_o[i] <= 1'b0;
         else if (set_en && in_rng)  map_o[i] <= 1'b1;
         else if (clr_en && in_rng)  map_o[i] <= 1'b0;
      end
   end

endmodule

// File: rtl/cap_free_scan.sv
module cap_free_scan #(
   parameter int AW      = 8,
   parameter int HDR_END = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] len,
   input  logic          used_i,
   output logic [AW:0]   idx_o,
   output logic          done_o,
   output logic          found_o,
   output logic [AW-1:0] offset_o
);

   localparam logic [AW:0] FIRST = (AW+1)'(HDR_END);
   localparam logic [AW:0] LAST  = (AW+1)'((1 << AW) - 1);

   logic        active;
   logic [AW:0] run_start;
   logic [AW:0] run_len;
   logic        fits;

   assign fits = !used_i && ((run_len + 1'b1) == {1'b0, len});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         idx_o     <= FIRST;
         run_start <= FIRST;
         run_len   <= '0;
         done_o    <= 1'b0;
         found_o   <= 1'b0;
         offset_o  <= '0;
      end else begin
         done_o <= 1'b0;
         if (start) begin
            active    <= 1'b1;
            idx_o     <= FIRST;
            run_start <= FIRST;
            run_len   <= '0;
            found_o   <= 1'b0;
         end else if (active) begin
            if (fits) begin
               found_o  <= 1'b1;
               offset_o <= run_start[AW-1:0];
               done_o   <= 1'b1;
               active   <= 1'b0;
            end else begin
               if (used_i) begin
                  run_start <= idx_o + 1'b1;
                  run_len   <= '0;
               end else begin
                  run_len <= run_len + 1'b1;
               end
               if (idx_o == LAST) begin
                  done_o <= 1'b1;
                  active <= 1'b0;
               end
               idx_o <= idx_o + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/cap_chain_engine.sv
module cap_chain_engine
   import cap_chain_pkg::*;
#(
   parameter int AW          = 8,
   parameter int HDR_END     = 64,
   parameter int HEAD_PTR    = 52,
   parameter int STATUS_ADDR = 6,
   parameter int CAP_BIT     = 4,
   parameter int HOP_LIMIT   = 48,
   localparam int SPACE      = 1 << AW,
   localparam int LOCK_W     = SPACE - HDR_END
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_cmd,
   input  logic [7:0]        req_id,
   input  logic [AW-1:0]     req_len,
   output logic              busy,
   output logic              done,
   output logic [AW-1:0]     result,
   output logic [AW-1:0]     mem_addr,
   output logic              mem_we,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   output logic [LOCK_W-1:0] lock_map
);

   localparam int HOP_W = $clog2(HOP_LIMIT + 1);
   localparam logic [AW-1:0] HEAD_A = AW'(HEAD_PTR);
   localparam logic [AW-1:0] STAT_A = AW'(STATUS_ADDR);

   if (HDR_END < 2 || HDR_END >= SPACE - 1) begin : g_bad_hdr
      $error("HDR_END must leave room above the header");
   end
   if (HEAD_PTR >= HDR_END || STATUS_ADDR >= HDR_END) begin : g_bad_ptr
      $error("head and status bytes must sit inside the header");
   end
   if (CAP_BIT > 7 || HOP_LIMIT < 1) begin : g_bad_misc
      $error("CAP_BIT or HOP_LIMIT out of range");
   end

   cap_state_e          state_q;
   cap_cmd_e            cmd_q;
   logic [7:0]          id_q;
   logic [AW-1:0]       len_q;
   logic [AW-1:0]       off_q;
   logic [AW-1:0]       prev_q;
   logic [7:0]          link_q;
   logic [7:0]          st_q;
   logic [HOP_W-1:0]    hops_q;
   logic [AW-1:0]       result_q;

   logic                scan_start, scan_done, scan_found;
   logic [AW:0]         scan_idx, scan_rel;
   logic [AW-1:0]       scan_off;
   logic                scan_used;
   logic                map_set, map_clr;

   assign scan_rel  = scan_idx - (AW+1)'(HDR_END);
   assign scan_used = lock_map[scan_rel[AW-1:0]];

   cap_free_scan #(.AW(AW), .HDR_END(HDR_END)) scan_i (
      .clk(clk), .rst_n(rst_n), .start(scan_start), .len(len_q),
      .used_i(scan_used), .idx_o(scan_idx), .done_o(scan_done),
      .found_o(scan_found), .offset_o(scan_off)
   );

   cap_lock_map #(.AW(AW), .HDR_END(HDR_END)) map_i (
      .clk(clk), .rst_n(rst_n), .set_en(map_set), .clr_en(map_clr),
      .base(off_q), .len(len_q), .map_o(lock_map)
   );

   assign busy   = (state_q != S_IDLE);
   assign done   = (state_q == S_FIN);
   assign result = result_q;

   // memory port and map strobes
   always_comb begin
      mem_addr   = '0;
      mem_we     = 1'b0;
      mem_wdata  = '0;
      map_set    = 1'b0;
      map_clr    = 1'b0;
      scan_start = (state_q == S_SCAN) && (hops_q == '0);
      unique case (state_q)
         S_W_ID:     begin mem_addr = off_q; mem_we = 1'b1; mem_wdata = id_q; end
         S_RD_HEAD:  mem_addr = HEAD_A;
         S_W_LINK:   begin mem_addr = off_q + 1'b1; mem_we = 1'b1; mem_wdata = link_q; end
         S_W_HEAD:   begin mem_addr = HEAD_A; mem_we = 1'b1; mem_wdata = 8'(off_q); end
         S_RD_ST,
         S_CHK_ST:   mem_addr = STAT_A;
         S_W_ST: begin
            mem_addr = STAT_A;
            mem_we   = 1'b1;
            if (cmd_q == CMD_ADD) begin
               mem_wdata = st_q | (8'd1 << CAP_BIT);
               map_set   = 1'b1;
            end else begin
               mem_wdata = st_q & ~(8'd1 << CAP_BIT);
            end
         end
         S_WALK_PTR: mem_addr = prev_q;
         S_WALK_ID:  mem_addr = off_q;
         S_RD_NEXT:  mem_addr = off_q + 1'b1;
         S_W_PREV: begin
            mem_addr  = prev_q;
            mem_we    = 1'b1;
            mem_wdata = link_q;
            map_clr   = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         cmd_q    <= CMD_NOP;
         id_q     <= '0;
         len_q    <= '0;
         off_q    <= '0;
         prev_q   <= '0;
         link_q   <= '0;
         st_q     <= '0;
         hops_q   <= '0;
         result_q <= '0;
      end else begin
         unique case (state_q)
            S_IDLE: if (req_valid) begin
               cmd_q  <= cap_cmd_e'(req_cmd);
               id_q   <= req_id;
               len_q  <= req_len;
               hops_q <= '0;
               unique case (cap_cmd_e'(req_cmd))
                  CMD_ADD: begin
                     if (req_len < AW'(2)) begin
                        result_q <= '0;
                        state_q  <= S_FIN;
                     end else begin
                        state_q  <= S_SCAN;
                     end
                  end
                  CMD_FIND, CMD_DEL: state_q <= S_CHK_ST;
                  default: begin
                     result_q <= '0;
                     state_q  <= S_FIN;
                  end
               endcase
            end
            S_SCAN: begin
               // hops_q doubles as the "scan launched" flag here
               hops_q <= HOP_W'(1);
               if (scan_done) begin
                  if (scan_found) begin
                     off_q   <= scan_off;
                     state_q <= S_W_ID;
                  end else begin
                     result_q <= '0;
                     state_q  <= S_FIN;
                  end
               end
            end
            S_W_ID:    state_q <= S_RD_HEAD;
            S_RD_HEAD: begin link_q <= mem_rdata; state_q <= S_W_LINK; end
            S_W_LINK:  state_q <= S_W_HEAD;
            S_W_HEAD:  state_q <= S_RD_ST;
            S_RD_ST:   begin st_q <= mem_rdata; state_q <= S_W_ST; end
            S_W_ST: begin
               if (cmd_q == CMD_ADD) result_q <= off_q;
               state_q <= S_FIN;
            end
            S_CHK_ST: begin
               if (!mem_rdata[CAP_BIT]) begin
                  result_q <= '0;
                  state_q  <= S_FIN;
               end else begin
                  prev_q  <= HEAD_A;
                  hops_q  <= '0;
                  state_q <= S_WALK_PTR;
               end
            end
            S_WALK_PTR: begin
               if (mem_rdata == 8'd0) begin
                  result_q <= '0;
                  state_q  <= S_FIN;
               end else begin
                  off_q   <= AW'(mem_rdata);
                  state_q <= S_WALK_ID;
               end
            end
            S_WALK_ID: begin
               if (mem_rdata == id_q) begin
                  if (cmd_q == CMD_FIND) begin
                     result_q <= off_q;
                     state_q  <= S_FIN;
                  end else begin
                     state_q  <= S_RD_NEXT;
                  end
               end else if (hops_q == HOP_W'(HOP_LIMIT - 1)) begin
                  result_q <= '0;
                  state_q  <= S_FIN;
               end else begin
                  prev_q  <= off_q + 1'b1;
                  hops_q  <= hops_q + 1'b1;
                  state_q <= S_WALK_PTR;
               end
            end
            S_RD_NEXT: begin link_q <= mem_rdata; state_q <= S_W_PREV; end
            S_W_PREV: begin
               result_q <= off_q;
               if (prev_q == HEAD_A && link_q == 8'd0) state_q <= S_RD_ST;
               else                                    state_q <= S_FIN;
            end
            S_FIN:   state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cap_chain_engine_chk.sv
module cap_chain_engine_chk
   import cap_chain_pkg::*;
#(
   parameter int AW          = 8,
   parameter int HDR_END     = 64,
   parameter int HEAD_PTR    = 52,
   parameter int STATUS_ADDR = 6,
   parameter int CAP_BIT     = 4,
   localparam int LOCK_W     = (1 << AW) - HDR_END
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              busy,
   input logic              done,
   input logic [AW-1:0]     result,
   input logic [AW-1:0]     mem_addr,
   input logic              mem_we,
   input logic [7:0]        mem_wdata,
   input logic [LOCK_W-1:0] lock_map,
   input cap_cmd_e          cmd_q
);

   logic [AW:0] res_rel;
   assign res_rel = {1'b0, result} - (AW+1)'(HDR_END);

   // R1
   a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R11
   a_r11_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_we);

   // R11
   a_r11_write_window: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr == AW'(STATUS_ADDR) || mem_addr == AW'(HEAD_PTR)
                  || mem_addr >= AW'(HDR_END)));

   // R6
   a_r6_add_locks: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cmd_q == CMD_ADD && result != '0)
         |-> (lock_map[res_rel[AW-1:0]] && lock_map[res_rel[AW-1:0] + 1'b1]));

   // R6
   a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !req_valid) |=> $stable(lock_map));

   // R5
   a_r5_status_set: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_addr == AW'(STATUS_ADDR) && cmd_q == CMD_ADD) |-> mem_wdata[CAP_BIT]);

   // R10
   a_r10_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_addr == AW'(STATUS_ADDR) && cmd_q == CMD_DEL) |-> !mem_wdata[CAP_BIT]);

endmodule

bind cap_chain_engine cap_chain_engine_chk #(
   .AW(AW), .HDR_END(HDR_END), .HEAD_PTR(HEAD_PTR),
   .STATUS_ADDR(STATUS_ADDR), .CAP_BIT(CAP_BIT)
) chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
   .result(result), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
   .lock_map(lock_map), .cmd_q(cmd_q)
);

// File: tb/cap_chain_engine_tb_top.sv
module cap_chain_engine_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [1:0]   req_cmd = '0;
   logic [7:0]   req_id = '0;
   logic [7:0]   req_len = '0;
   logic         busy, done, mem_we;
   logic [7:0]   result, mem_addr, mem_wdata, mem_rdata;
   logic [191:0] lock_map;

   logic [7:0]   cfg [256];
   logic         tb_we = 1'b0;
   logic [7:0]   tb_addr = '0, tb_data = '0;
   int           wr_cnt = 0;
   int           checks = 0, fails = 0;

   always #5 clk = ~clk;

   cap_chain_engine dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
      .req_id(req_id), .req_len(req_len), .busy(busy), .done(done),
      .result(result), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .lock_map(lock_map)
   );

   assign mem_rdata = cfg[mem_addr];

   always @(posedge clk) begin
      if (mem_we) begin
         cfg[mem_addr] <= mem_wdata;
         wr_cnt <= wr_cnt + 1;
      end else if (tb_we) begin
         cfg[tb_addr] <= tb_data;
      end
   end

   typedef struct packed {
      logic [1:0] cmd;
      logic [7:0] id;
      logic [7:0] len;
      logic [7:0] exp;
   } vec_t;

   // cmd: 0 add, 1 find, 2 remove
   localparam vec_t VEC [15] = '{
      '{2'd1, 8'h05, 8'd0, 8'd0},   // R7 flag clear
      '{2'd0, 8'h05, 8'd4, 8'd64},  // R2
      '{2'd0, 8'h10, 8'd8, 8'd68},
      '{2'd0, 8'h11, 8'd2, 8'd76},
      '{2'd1, 8'h05, 8'd0, 8'd64},  // R7 tail of chain
      '{2'd1, 8'h10, 8'd0, 8'd68},
      '{2'd1, 8'h22, 8'd0, 8'd0},   // R7 zero link
      '{2'd2, 8'h10, 8'd8, 8'd68},  // R9 middle entry
      '{2'd1, 8'h10, 8'd0, 8'd0},
      '{2'd0, 8'h12, 8'd4, 8'd68},  // R2 reuse freed hole
      '{2'd0, 8'h13, 8'd6, 8'd78},  // R2 skip too-small hole
      '{2'd2, 8'h13, 8'd6, 8'd78},
      '{2'd2, 8'h12, 8'd4, 8'd68},
      '{2'd2, 8'h11, 8'd2, 8'd76},
      '{2'd2, 8'h05, 8'd4, 8'd64}   // R10 chain empties
   };

   task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic poke(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      tb_addr = a; tb_data = d; tb_we = 1'b1;
      @(negedge clk);
      tb_we = 1'b0;
   endtask

   task automatic do_op(input logic [1:0] c, input logic [7:0] id, input logic [7:0] len,
                        output logic [7:0] res, output int lat);
      int guard;
      @(negedge clk);
      while (busy) @(negedge clk);
      req_valid = 1'b1; req_cmd = c; req_id = id; req_len = len;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      guard = 0;
      while (!done && guard < 5000) begin
         @(negedge clk);
         lat++;
         guard++;
      end
      if (!done) begin
         checks++; fails++;
         $display("FAIL R1 watchdog actual=no_done expected=done");
      end
      res = result;
   endtask

   initial begin
      logic [7:0] res;
      int lat, w0;
      for (int i = 0; i < 256; i++) cfg[i] = 8'h00;
      cfg[6] = 8'h02;
      repeat (3) @(negedge clk);
      // R13 reset state
      chk("R13 busy", 256'(busy), 256'd0);
      chk("R13 done", 256'(done), 256'd0);
      chk("R13 mem_we", 256'(mem_we), 256'd0);
      chk("R13 lock_map", 256'(lock_map), 256'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 15; i++) begin
         do_op(VEC[i].cmd, VEC[i].id, VEC[i].len, res, lat);
         case (VEC[i].cmd)
            2'd0:    chk($sformatf("R2 vec%0d add result", i), 256'(res), 256'(VEC[i].exp));
            2'd1:    chk($sformatf("R7 vec%0d find result", i), 256'(res), 256'(VEC[i].exp));
            default: chk($sformatf("R9 vec%0d remove result", i), 256'(res), 256'(VEC[i].exp));
         endcase
         if (i == 1) begin
            @(negedge clk);
            chk("R1 done single cycle", 256'({done, busy}), 256'd0);
         end
         if (i == 3) begin
            chk("R4 head", 256'(cfg[8'h34]), 256'd76);
            chk("R4 id76", 256'(cfg[76]), 256'h11);
            chk("R4 link77", 256'(cfg[77]), 256'd68);
            chk("R4 id68", 256'(cfg[68]), 256'h10);
            chk("R4 link69", 256'(cfg[69]), 256'd64);
            chk("R4 link65", 256'(cfg[65]), 256'd0);
            chk("R5 status", 256'(cfg[6]), 256'h12);
            chk("R6 locks", 256'(lock_map[14:0]), 256'h3fff);
         end
         if (i == 7) begin
            chk("R9 patched link", 256'(cfg[77]), 256'd64);
            chk("R9 unlock", 256'(lock_map[13:0]), 256'h300f);
         end
      end
      chk("R10 status cleared", 256'(cfg[6]), 256'h02);
      chk("R10 head zero", 256'(cfg[8'h34]), 256'd0);
      chk("R9 all unlocked", 256'(lock_map), 256'd0);

      // R12 no-op code
      w0 = wr_cnt;
      do_op(2'd3, 8'h01, 8'd4, res, lat);
      chk("R12 nop result", 256'(res), 256'd0);
      chk("R12 nop writes", 256'(wr_cnt - w0), 256'd0);

      // R3 short length
      w0 = wr_cnt;
      do_op(2'd0, 8'h01, 8'd1, res, lat);
      chk("R3 short result", 256'(res), 256'd0);
      chk("R3 short writes", 256'(wr_cnt - w0), 256'd0);

      // R2 run ending exactly at 255
      do_op(2'd0, 8'h40, 8'd192, res, lat);
      chk("R2 full-space add", 256'(res), 256'd64);
      chk("R6 all locked", 256'(lock_map), {64'd0, {192{1'b1}}});

      // R3 no room
      w0 = wr_cnt;
      do_op(2'd0, 8'h41, 8'd2, res, lat);
      chk("R3 no-fit result", 256'(res), 256'd0);
      chk("R3 no-fit writes", 256'(wr_cnt - w0), 256'd0);
      chk("R3 no-fit locks", 256'(lock_map), {64'd0, {192{1'b1}}});

      // R9 absent identifier
      w0 = wr_cnt;
      do_op(2'd2, 8'h55, 8'd4, res, lat);
      chk("R9 absent result", 256'(res), 256'd0);
      chk("R9 absent writes", 256'(wr_cnt - w0), 256'd0);

      do_op(2'd2, 8'h40, 8'd192, res, lat);
      chk("R9 remove big", 256'(res), 256'd64);
      chk("R10 status after big", 256'(cfg[6]), 256'h02);

      // R8 self-looping chain
      poke(8'd6, 8'h12);
      poke(8'h34, 8'h40);
      poke(8'h40, 8'h99);
      poke(8'h41, 8'h40);
      w0 = wr_cnt;
      do_op(2'd1, 8'h77, 8'd0, res, lat);
      chk("R8 loop result", 256'(res), 256'd0);
      chk("R8 loop latency", 256'(lat), 256'd98);
      chk("R11 find writes", 256'(wr_cnt - w0), 256'd0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #2000000;
      fails++;
      $display("FAIL R1 global watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule